// File: doc/BRIEF.md
# Ethernet PHY Management Slave with Change Interrupt

This block is the serial management port of a 10/100 Ethernet physical-layer device. A station manager drives a management clock and a single shared data line; the line is split here into an input, an output and an output enable, and the pad combines them outside the block. All state is clocked on the rising edge of the management clock, which may run at up to 2.5 MHz. The block decodes read and write frames that carry its own strapped 5-bit device address. It serves a small register file: a control word, an advertisement word, an event-status word and an event-enable word.

Each event input is sampled on every clock edge. A bit of the event-status word latches whenever its input's sample differs from the sample before. The latched bits, masked by the event-enable word, drive an interrupt output. That output is a register, so it only ever moves on a management-clock edge. Reading the event-status word returns the latched bits and clears them in the same transaction. Two control bits are brought out as the isolate and full-duplex controls for the rest of the device.

Top module: `phy_mgmt_slave`

## Requirements
- R1: After reset, register 0 reads 0x3100, register 4 reads 0x01E1, registers 17 and 18 read 0, the interrupt output is low and the data line is not driven.
- R2: A read frame has 32 ones, the start pair 0 then 1, opcode 1 then 0, the 5-bit device address and the 5-bit register address, all MSB first. The slave leaves the line undriven for the first turnaround bit and drives 0 for the second. It then drives the 16 data bits MSB first, one per rising edge, and releases the line afterwards.
- R3: A write frame uses opcode 0 then 1, followed by two ignored turnaround bits and 16 data bits MSB first. The new value is in effect from the edge that samples the last data bit and reads back unchanged.
- R4: A frame whose device address differs from the strap never drives the line and changes no register.
- R5: A frame with opcode 00 or 11 is ignored: no drive and no register change.
- R6: A frame preceded by fewer than 32 consecutive ones is ignored.
- R7: Bit i of register 17 sets when event input i is sampled at a value different from its previous sample, on a rising edge or a falling one.
- R8: The interrupt output is high after any edge at which a set bit of register 17 has its enable bit set in register 18. Register 18 holds one enable bit per event in its low bits, and its unused bits read 0.
- R9: A read of register 17 returns the bits latched before its register-address edge and clears them at that edge, and the interrupt falls at the same edge. An event detected at that very edge stays latched.
- R10: The isolate output follows bit 10 of register 0, and the full-duplex output follows bit 8 (1 = full duplex).
- R11: Registers other than 0, 4, 17 and 18 read 0 and ignore writes, and writes to register 17 are ignored.
- R12: When the strapped address is 00000, bit 10 of register 0 resets to 1, so register 0 reads 0x3500 and the isolate output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| phyAddr | input | 5 | Strapped device address |
| mdioIn | input | 1 | Sampled value of the management data line |
| mdioOut | output | 1 | Value driven on the data line when enabled |
| mdioOe | output | 1 | Output enable for the data line |
| eventIn | input | NUM_EV | Event sources whose changes are latched |
| intOut | output | 1 | Interrupt, high while an enabled event bit is latched |
| isolate | output | 1 | Isolate control, bit 10 of register 0 |
| fullDuplex | output | 1 | Duplex control, bit 8 of register 0 |

## Verification
A framing state that is off by one edge shows up in the first turnaround of a read. The line is driven where it should float, or the data is shifted by one bit and lands off the 16-bit boundary. A bad address or opcode decode shows up in the same frame as drive on the wrong frame or as a register that has silently changed, and the next readback exposes it. A wrong latch or clear in the event logic shows on the interrupt one clock edge after the event toggles, and on the very next read of register 17. A wrong reset value shows on the first register sweep.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] REG_CTRL   = 5'd0;
  localparam logic [ADDR_W-1:0] REG_ADV    = 5'd4;
  localparam logic [ADDR_W-1:0] REG_EVSTAT = 5'd17;
  localparam logic [ADDR_W-1:0] REG_EVEN   = 5'd18;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  // Strobes from the frame sequencer to the register datapath.
  typedef struct packed {
    logic              rdLoad;
    logic              rdShift;
    logic              wrStb;
    logic [ADDR_W-1:0] regAddr;
    logic [DATA_W-1:0] wrData;
  } mgmtStb_t;
endpackage

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic              mdioIn,
  input  logic              rdBit,
  output logic              mdioOut,
  output logic              mdioOe,
  output mgmtStb_t          stb
);
  localparam int ONES_W = $clog2(PREAMBLE_LEN + 1);
  localparam int HDR_W  = 2 + 2 * ADDR_W;
  localparam logic [ONES_W-1:0] ONES_FULL = ONES_W'(PREAMBLE_LEN);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_HDR, S_RTA1, S_RTA2, S_RDATA, S_WTA, S_WDATA
  } state_t;

  state_t            state, stateNxt;
  logic [ONES_W-1:0] ones, onesNxt;
  logic [3:0]        cnt, cntNxt;
  logic [HDR_W-1:0]  hdr, hdrNxt, hdrIn;
  logic [ADDR_W-1:0] regQ, regNxt;
  logic [DATA_W-1:0] wrSh, wrShNxt;

  assign hdrIn = {hdr[HDR_W-2:0], mdioIn};

  always_comb begin
    stateNxt    = state;
    onesNxt     = '0;
    cntNxt      = cnt;
    hdrNxt      = hdr;
    regNxt      = regQ;
    wrShNxt     = wrSh;
    stb         = '0;
    stb.regAddr = regQ;
    stb.wrData  = {wrSh[DATA_W-2:0], mdioIn};
    unique case (state)
      S_IDLE: begin
        if (mdioIn) begin
          onesNxt = (ones == ONES_FULL) ? ones : ones + 1'b1;
        end else if (ones == ONES_FULL) begin
          stateNxt = S_START;
        end
      end
      S_START: begin
        cntNxt   = '0;
        stateNxt = mdioIn ? S_HDR : S_IDLE;
      end
      S_HDR: begin
        hdrNxt = hdrIn;
        cntNxt = cnt + 1'b1;
        if (cnt == 4'd1 && hdrIn[1:0] != OP_RD && hdrIn[1:0] != OP_WR) begin
          stateNxt = S_IDLE;
        end else if (cnt == 4'(HDR_W - 1)) begin
          cntNxt = '0;
          regNxt = hdrIn[ADDR_W-1:0];
          if (hdrIn[2*ADDR_W-1:ADDR_W] != phyAddr) begin
            stateNxt = S_IDLE;
          end else if (hdrIn[HDR_W-1:HDR_W-2] == OP_RD) begin
            stb.rdLoad  = 1'b1;
            stb.regAddr = hdrIn[ADDR_W-1:0];
            stateNxt    = S_RTA1;
          end else begin
            stateNxt = S_WTA;
          end
        end
      end
      S_RTA1: stateNxt = S_RTA2;
      S_RTA2: begin
        cntNxt   = '0;
        stateNxt = S_RDATA;
      end
      S_RDATA: begin
        if (cnt == 4'(DATA_W - 1)) begin
          stateNxt = S_IDLE;
        end else begin
          stb.rdShift = 1'b1;
          cntNxt      = cnt + 1'b1;
        end
      end
      S_WTA: begin
        if (cnt == 4'd1) begin
          cntNxt   = '0;
          stateNxt = S_WDATA;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      S_WDATA: begin
        wrShNxt = {wrSh[DATA_W-2:0], mdioIn};
        if (cnt == 4'(DATA_W - 1)) begin
          stb.wrStb = 1'b1;
          stateNxt  = S_IDLE;
        end else begin
          cntNxt = cnt + 1'b1;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      ones  <= '0;
      cnt   <= '0;
      hdr   <= '0;
      regQ  <= '0;
      wrSh  <= '0;
    end else begin
      state <= stateNxt;
      ones  <= onesNxt;
      cnt   <= cntNxt;
      hdr   <= hdrNxt;
      regQ  <= regNxt;
      wrSh  <= wrShNxt;
    end
  end

  assign mdioOe  = (state == S_RTA2) || (state == S_RDATA);
  assign mdioOut = (state == S_RDATA) && rdBit;
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int          NUM_EV   = 8,
  parameter logic [15:0] CTRL_RST = 16'h3100,
  parameter logic [15:0] ADV_RST  = 16'h01E1,
  parameter int          ISO_BIT  = 10,
  parameter int          FDX_BIT  = 8
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] phyAddr,
  input  logic [NUM_EV-1:0] eventIn,
  input  mgmtStb_t          stb,
  output logic              rdBit,
  output logic              intOut,
  output logic              isolate,
  output logic              fullDuplex,
  output logic [NUM_EV-1:0] evStatus,
  output logic [NUM_EV-1:0] evEnable
);
  localparam logic [DATA_W-1:0] ISO_MASK = DATA_W'(1) << ISO_BIT;

  logic [DATA_W-1:0] ctrlQ, advQ, rdSh, rdMux, ctrlRst;
  logic [NUM_EV-1:0] statQ, statNxt, enQ, enNxt, evPrev;
  logic              statClr, wrCtrl, wrAdv, wrEn;

  assign ctrlRst = CTRL_RST | ((phyAddr == '0) ? ISO_MASK : '0);
  assign statClr = stb.rdLoad && (stb.regAddr == REG_EVSTAT);
  assign wrCtrl  = stb.wrStb && (stb.regAddr == REG_CTRL);
  assign wrAdv   = stb.wrStb && (stb.regAddr == REG_ADV);
  assign wrEn    = stb.wrStb && (stb.regAddr == REG_EVEN);
  assign enNxt   = wrEn ? stb.wrData[NUM_EV-1:0] : enQ;

  // One change latch per event source.
  for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
    assign statNxt[i] = (statQ[i] && !statClr) || (eventIn[i] != evPrev[i]);
    always_ff @(posedge mdc or negedge rstN) begin
      if (!rstN) begin
        statQ[i]  <= 1'b0;
        evPrev[i] <= 1'b0;
      end else begin
        statQ[i]  <= statNxt[i];
        evPrev[i] <= eventIn[i];
      end
    end
  end

  always_comb begin
    unique case (stb.regAddr)
      REG_CTRL:   rdMux = ctrlQ;
      REG_ADV:    rdMux = advQ;
      REG_EVSTAT: rdMux = DATA_W'(statQ);
      REG_EVEN:   rdMux = DATA_W'(enQ);
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      ctrlQ  <= ctrlRst;
      advQ   <= ADV_RST;
      enQ    <= '0;
      rdSh   <= '0;
      intOut <= 1'b0;
    end else begin
      if (wrCtrl) ctrlQ <= stb.wrData;
      if (wrAdv)  advQ  <= stb.wrData;
      enQ <= enNxt;
      if (stb.rdLoad)       rdSh <= rdMux;
      else if (stb.rdShift) rdSh <= {rdSh[DATA_W-2:0], 1'b0};
      intOut <= |(statNxt & enNxt);
    end
  end

  assign rdBit      = rdSh[DATA_W-1];
  assign isolate    = ctrlQ[ISO_BIT];
  assign fullDuplex = ctrlQ[FDX_BIT];
  assign evStatus   = statQ;
  assign evEnable   = enQ;
endmodule

// File: rtl/phy_mgmt_slave.sv
module phy_mgmt_slave
  import phy_mgmt_pkg::*;
#(
  parameter int NUM_EV       = 8,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              mdc,
  input  logic              rstN,
  input  logic [4:0]        phyAddr,
  input  logic              mdioIn,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic [NUM_EV-1:0] eventIn,
  output logic              intOut,
  output logic              isolate,
  output logic              fullDuplex
);
  mgmtStb_t          stb;
  logic              rdBit;
  logic [NUM_EV-1:0] evStatus, evEnable;

  phy_mgmt_ctrl #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_ctrl (
    .mdc(mdc), .rstN(rstN), .phyAddr(phyAddr), .mdioIn(mdioIn),
    .rdBit(rdBit), .mdioOut(mdioOut), .mdioOe(mdioOe), .stb(stb)
  );

  phy_mgmt_regs #(.NUM_EV(NUM_EV)) u_regs (
    .mdc(mdc), .rstN(rstN), .phyAddr(phyAddr), .eventIn(eventIn),
    .stb(stb), .rdBit(rdBit), .intOut(intOut), .isolate(isolate),
    .fullDuplex(fullDuplex), .evStatus(evStatus), .evEnable(evEnable)
  );
endmodule

// File: rtl/phy_mgmt_slave_chk.sv
module phy_mgmt_slave_chk #(
  parameter int NUM_EV = 8
) (
  input logic              mdc,
  input logic              rstN,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic              intOut,
  input logic [NUM_EV-1:0] eventIn,
  input logic [NUM_EV-1:0] evStatus,
  input logic [NUM_EV-1:0] evEnable
);
  logic [NUM_EV-1:0] prevEv, chg;
  logic [4:0]        oeRun;

  always_ff @(posedge mdc or negedge rstN) begin
    if (!rstN) begin
      prevEv <= '0;
      oeRun  <= '0;
    end else begin
      prevEv <= eventIn;
      oeRun  <= mdioOe ? oeRun + 1'b1 : '0;
    end
  end
  assign chg = eventIn ^ prevEv;

  p_quiet_reset_r1: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(rstN) |-> (!mdioOe && !intOut));

  p_ta_zero_r2: assert property (@(posedge mdc) disable iff (!rstN)
    $rose(mdioOe) |-> !mdioOut);

  p_drive_len_r2: assert property (@(posedge mdc) disable iff (!rstN)
    mdioOe |-> (oeRun < 5'd17));

  p_change_latch_r7: assert property (@(posedge mdc) disable iff (!rstN)
    (|chg) |=> ((evStatus & $past(chg)) == $past(chg)));

  p_int_cause_r8: assert property (@(posedge mdc) disable iff (!rstN)
    intOut |-> (|(evStatus & evEnable)));
endmodule

bind phy_mgmt_slave phy_mgmt_slave_chk #(.NUM_EV(NUM_EV)) u_chk (
  .mdc(mdc), .rstN(rstN), .mdioOut(mdioOut), .mdioOe(mdioOe),
  .intOut(intOut), .eventIn(eventIn), .evStatus(evStatus), .evEnable(evEnable)
);

// File: tb/phy_mgmt_slave_bench.sv
module phy_mgmt_slave_bench;
  localparam int NEV = 8;

  logic           mdc = 1'b0;
  logic           rstN = 1'b0;
  logic [4:0]     strap = 5'd9;
  logic           mdioIn = 1'b1;
  logic [NEV-1:0] ev = '0;
  logic           mdioOut, mdioOe, intOut, isolate, fullDuplex;

  phy_mgmt_slave #(.NUM_EV(NEV)) u_phy_mgmt_slave (
    .mdc(mdc), .rstN(rstN), .phyAddr(strap), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .eventIn(ev), .intOut(intOut),
    .isolate(isolate), .fullDuplex(fullDuplex)
  );

  always #5 mdc = ~mdc;

  int          checks = 0, errors = 0;
  bit          finished = 0;
  logic        drove, taOk;
  logic [15:0] rdData;
  logic [15:0] expCtrl, expAdv, expEn, expStat;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, input logic [NEV-1:0] tog);
    @(negedge mdc);
    if (mdioOe) drove = 1'b1;
    mdioIn = b;
    ev = ev ^ tog;
  endtask

  task automatic doFrame(input int preLen, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] wd, input logic [NEV-1:0] tog);
    drove = 1'b0; taOk = 1'b1; rdData = '0;
    if (preLen < 32) begin sendBit(1'b0, '0); sendBit(1'b0, '0); end
    for (int i = 0; i < preLen; i++) sendBit(1'b1, '0);
    sendBit(1'b0, '0); sendBit(1'b1, '0);
    sendBit(op[1], '0); sendBit(op[0], '0);
    for (int i = 4; i >= 0; i--) sendBit(phy[i], '0);
    for (int i = 4; i >= 1; i--) sendBit(rg[i], '0);
    sendBit(rg[0], tog);
    if (op == 2'b10) begin
      @(negedge mdc); mdioIn = 1'b1;
      if (mdioOe) begin drove = 1'b1; taOk = 1'b0; end
      @(negedge mdc);
      if (mdioOe) drove = 1'b1;
      if (!(mdioOe && !mdioOut)) taOk = 1'b0;
      for (int i = 0; i < 16; i++) begin
        @(negedge mdc);
        if (mdioOe) drove = 1'b1; else taOk = 1'b0;
        rdData = {rdData[14:0], mdioOut};
      end
      @(negedge mdc);
      if (mdioOe) begin drove = 1'b1; taOk = 1'b0; end
    end else begin
      sendBit(1'b1, '0); sendBit(1'b0, '0);
      for (int i = 15; i >= 0; i--) sendBit(wd[i], '0);
      sendBit(1'b1, '0);
    end
  endtask

  function automatic logic [15:0] expReg(input logic [4:0] r);
    case (r)
      5'd0:    return expCtrl;
      5'd4:    return expAdv;
      5'd17:   return expStat;
      5'd18:   return expEn;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic readChk(input string tag, input logic [4:0] rg, input logic [15:0] exp);
    doFrame(32, 2'b10, strap, rg, 16'h0, '0);
    chk(tag, {16'h0, rdData}, {16'h0, exp});
    if (rg == 5'd17) expStat = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge mdc);
    rstN = 1'b1;
    @(negedge mdc);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=running exp=done");
      report();
      $finish;
    end
  end

  initial begin
    expCtrl = 16'h3100; expAdv = 16'h01E1; expEn = '0; expStat = '0;
    doReset();

    // R1: quiet outputs after reset
    chk("R1 intOut", intOut, 0);
    chk("R1 mdioOe", mdioOe, 0);
    chk("R10 isolate reset", isolate, 0);
    chk("R10 fullDuplex reset", fullDuplex, 1);

    // R1 / R11: full register sweep, R2 framing on each
    for (int r = 0; r < 32; r++) begin
      doFrame(32, 2'b10, strap, 5'(r), 16'h0, '0);
      chk($sformatf("R1 R11 reg %0d", r), rdData, expReg(5'(r)));
      chk($sformatf("R2 turnaround reg %0d", r), taOk, 1);
    end

    // R4: address sweep, only the strap answers
    for (int a = 0; a < 32; a++) begin
      doFrame(32, 2'b10, 5'(a), 5'd4, 16'h0, '0);
      chk($sformatf("R4 addr %0d drive", a), drove, (5'(a) == strap));
    end

    // R3 / R10: writes take effect and show at the ports
    doFrame(32, 2'b01, strap, 5'd4, 16'hA5C3, '0); expAdv = 16'hA5C3;
    chk("R3 write no drive", drove, 0);
    readChk("R3 adv readback", 5'd4, expAdv);
    doFrame(32, 2'b01, strap, 5'd0, 16'h0400, '0); expCtrl = 16'h0400;
    chk("R10 isolate set", isolate, 1);
    chk("R10 half duplex", fullDuplex, 0);
    readChk("R3 ctrl readback", 5'd0, expCtrl);
    doFrame(32, 2'b01, strap, 5'd0, 16'h0100, '0); expCtrl = 16'h0100;
    chk("R10 isolate clear", isolate, 0);
    chk("R10 full duplex", fullDuplex, 1);
    doFrame(32, 2'b01, strap, 5'd18, 16'hFFFF, '0); expEn = 16'h00FF;
    readChk("R8 enable width", 5'd18, expEn);

    // R4: write to another address changes nothing
    doFrame(32, 2'b01, strap ^ 5'd3, 5'd4, 16'h1234, '0);
    chk("R4 wrong addr write drive", drove, 0);
    readChk("R4 wrong addr write", 5'd4, expAdv);

    // R11: writes to status and unimplemented registers
    doFrame(32, 2'b01, strap, 5'd17, 16'hFFFF, '0);
    readChk("R11 status write ignored", 5'd17, 16'h0);
    doFrame(32, 2'b01, strap, 5'd7, 16'h1234, '0);
    readChk("R11 reg 7 write ignored", 5'd7, 16'h0);

    // R5: illegal opcodes
    doFrame(32, 2'b00, strap, 5'd4, 16'h0000, '0);
    chk("R5 op00 drive", drove, 0);
    doFrame(32, 2'b11, strap, 5'd4, 16'h0000, '0);
    chk("R5 op11 drive", drove, 0);
    readChk("R5 adv unchanged", 5'd4, expAdv);

    // R6: short preamble
    doFrame(31, 2'b10, strap, 5'd4, 16'h0, '0);
    chk("R6 short read drive", drove, 0);
    doFrame(31, 2'b01, strap, 5'd4, 16'h0000, '0);
    readChk("R6 short write ignored", 5'd4, expAdv);

    // R7 / R8 / R9: each event, both edges
    for (int i = 0; i < NEV; i++) begin
      @(negedge mdc); ev[i] = 1'b1;
      @(negedge mdc);
      chk($sformatf("R8 int on rise ev%0d", i), intOut, 1);
      expStat = 16'(1) << i;
      readChk($sformatf("R7 rise latch ev%0d", i), 5'd17, expStat);
      chk($sformatf("R9 int cleared ev%0d", i), intOut, 0);
      @(negedge mdc); ev[i] = 1'b0;
      @(negedge mdc);
      chk($sformatf("R8 int on fall ev%0d", i), intOut, 1);
      expStat = 16'(1) << i;
      readChk($sformatf("R7 fall latch ev%0d", i), 5'd17, expStat);
    end

    // R8: enable gating
    doFrame(32, 2'b01, strap, 5'd18, 16'h000F, '0); expEn = 16'h000F;
    @(negedge mdc); ev[6] = 1'b1;
    @(negedge mdc);
    chk("R8 masked event no int", intOut, 0);
    ev[2] = 1'b1;
    @(negedge mdc);
    chk("R8 enabled event int", intOut, 1);
    expStat = 16'h0044;
    readChk("R9 masked and enabled latched", 5'd17, expStat);
    @(negedge mdc); ev[6] = 1'b0; ev[2] = 1'b0;
    @(negedge mdc);
    expStat = 16'h0044;
    readChk("R7 both fall", 5'd17, expStat);

    // R9: event at the clearing edge survives
    @(negedge mdc); ev[1] = 1'b1;
    @(negedge mdc);
    doFrame(32, 2'b10, strap, 5'd17, 16'h0, 8'h08);
    chk("R9 read before clear", rdData, 16'h0002);
    chk("R9 int held by new event", intOut, 1);
    readChk("R9 same-edge event kept", 5'd17, 16'h0008);
    chk("R9 int low after clear", intOut, 0);

    // R12: zero strap resets with isolate set
    ev = '0;
    strap = 5'd0;
    doReset();
    chk("R12 isolate at zero strap", isolate, 1);
    readChk("R12 ctrl reset value", 5'd0, 16'h3500);

    finished = 1;
    report();
    $finish;
  end
endmodule